// File: doc/BRIEF.md
# Smart card interface interrupt controller

This block merges the event sources of a smart card interface onto a single active-high interrupt line. Six engine events arrive as one-cycle pulses: the transmit holding buffer moving into the shift register, the card supply voltage leaving its window, expiry of the waiting-time counter, the end of a transmission, the end of a reception, and a parity error. A seventh source is an edge on the asynchronous card-presence input. That input is synchronized, and a configuration bit chooses whether a rising or a falling edge counts.

Each source owns a latched flag and an enable bit. Software clears flags by writing ones to the flag register. For polling without interrupts, a separate status register records every event whether or not its source is enabled. If software reads the flag register while new events arrive, those events are held back and committed on the cycle after the read. A read therefore never shows half of an update, and an event that arrives during a read is still kept.

Top module: `sc_irq_ctrl`

## Requirements
- R1: Flag register (address 0) bit order: bit 0 transmit buffer moved, 1 supply fault, 2 waiting-time expiry, 3 transmission done, 4 reception done, 5 parity error, 6 card-presence edge. An event pulse on an enabled source sets its flag at the next clock edge.
- R2: `irq` is high exactly when some flag bit and the matching bit of the enable register (address 1, same bit order) are both set. It follows the registers with no further delay.
- R3: A flag stays set until a write to address 0 carries a one in its bit position. Zero bits in that write, and bits 7 and above, change nothing.
- R4: When a clearing write and a new event of the same enabled source fall in the same cycle, the flag ends up set.
- R5: An event in a cycle where `bus_rd` is high with address 0 does not appear in that read's data and does not change the flags or `irq` in that cycle. It is committed on the first later cycle without such a read. Several events of one source during a read run merge into one flag.
- R6: An event on a disabled source leaves its flag clear and does not raise `irq`.
- R7: Status register (address 2) bits 0 to 5 latch every event of sources 0 to 5, regardless of enable or reads. They are cleared by writing ones to address 2. Bit 6 reads the synchronized card-presence level and ignores writes.
- R8: Config register (address 3) bit 0 selects the active card-presence edge: 1 for rising, 0 for falling. Only the selected edge sets flag bit 6, and only while enable bit 6 is set.
- R9: After reset the flags, enables, status, config, read data and `irq` are all zero.
- R10: `bus_rdata` is registered. It shows the addressed register in the cycle after a `bus_rd` strobe, keeps that value until the next strobe, and has zeros in unused bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ev_txbuf | input | 1 | Transmit buffer moved to shift register (pulse) |
| ev_vcc | input | 1 | Supply voltage out of range (pulse) |
| ev_wt | input | 1 | Waiting-time counter expired (pulse) |
| ev_txdone | input | 1 | Transmission complete (pulse) |
| ev_rxdone | input | 1 | Reception complete (pulse) |
| ev_parity | input | 1 | Parity error detected (pulse) |
| card_pres | input | 1 | Asynchronous card-presence level |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench aims at events that coincide with a flag-register read. It checks back-to-back reads with repeated events, which must merge into one flag and appear only after the read run ends. A design without the hold-back would either show a bit in the wrong read or drop the event. The bench also sends a clearing write and an event to the same bit in the same cycle, where a design that gives the clear priority loses the event. It sends events to disabled sources, which must leave `irq` low while the status register still records them. Card-presence edges are driven in both directions under both settings of the edge-select bit, which exposes an inverted or ignored selection.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
   localparam int SRC_N    = 6;          // engine event sources
   localparam int FLAG_N   = SRC_N + 1;  // plus card-presence edge
   localparam int PRES_BIT = SRC_N;
   localparam int ADDR_W   = 2;

   localparam logic [ADDR_W-1:0] A_FLAG = 2'd0;
   localparam logic [ADDR_W-1:0] A_ENA  = 2'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
   localparam logic [ADDR_W-1:0] A_CFG  = 2'd3;
endpackage

// File: rtl/sc_irq_sync_edge.sv
module sc_irq_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic rise_sel,
   output logic level,
   output logic edge_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sc_irq_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign level      = sync_q[STAGES-1];
   assign edge_pulse = rise_sel ? (level & ~prev_q) : (~level & prev_q);

   // R8: a detected edge cannot repeat on the next cycle while the selection holds
   assert_single_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse ##1 $stable(rise_sel) |-> !edge_pulse);
endmodule

// File: rtl/sc_irq_defer.sv
module sc_irq_defer #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_en,
   input  logic [W-1:0] ev,
   output logic [W-1:0] commit
);
   if (W < 1) begin : g_bad_width
      $error("sc_irq_defer: W must be positive");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       hold_q <= 1'b0;
         else if (hold_en) hold_q <= hold_q | ev[i];
         else              hold_q <= 1'b0;
      end

      assign commit[i] = ~hold_en & (hold_q | ev[i]);

      // R5: a held event is released on the first cycle without a read
      assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (hold_en && ev[i]) ##1 !hold_en |-> commit[i]);
      // R5: nothing stays parked once a read run has ended
      assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !hold_en |=> !hold_q);
   end
endmodule

// File: rtl/sc_irq_ctrl.sv
module sc_irq_ctrl
   import sc_irq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_txbuf,
   input  logic              ev_vcc,
   input  logic              ev_wt,
   input  logic              ev_txdone,
   input  logic              ev_rxdone,
   input  logic              ev_parity,
   input  logic              card_pres,
   output logic              irq
);
   if (DATA_W < FLAG_N) begin : g_bad_data_w
      $error("sc_irq_ctrl: DATA_W must hold all flag bits");
   end

   localparam int PAD_W = DATA_W - FLAG_N;

   logic [FLAG_N-1:0] en_q, flag_q, ev_vec, gated, set_vec, clr_flag;
   logic [SRC_N-1:0]  stat_q, clr_stat;
   logic              cfg_rise_q, pres_level, pres_edge, rd_flag;
   logic [DATA_W-1:0] rd_mux, rdata_q;

   assign ev_vec  = {pres_edge, ev_parity, ev_rxdone, ev_txdone, ev_wt, ev_vcc, ev_txbuf};
   assign gated   = ev_vec & en_q;
   assign rd_flag = bus_rd && (bus_addr == A_FLAG);

   assign clr_flag = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[FLAG_N-1:0] : '0;
   assign clr_stat = (bus_wr && bus_addr == A_STAT) ? bus_wdata[SRC_N-1:0]  : '0;

   sc_irq_sync_edge #(.STAGES(SYNC_STAGES)) u_pres (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (card_pres),
      .rise_sel  (cfg_rise_q),
      .level     (pres_level),
      .edge_pulse(pres_edge)
   );

   sc_irq_defer #(.W(FLAG_N)) u_defer (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_en(rd_flag),
      .ev     (gated),
      .commit (set_vec)
   );

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= (flag_q[i] & ~clr_flag[i]) | set_vec[i];
      end

      // R3: a flag only drops through a clearing write
      assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr_flag[i]) |=> flag_q[i]);
      // R4: a committed event beats a same-cycle clear
      assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> flag_q[i]);
   end

   for (genvar s = 0; s < SRC_N; s++) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[s] <= 1'b0;
         else        stat_q[s] <= (stat_q[s] & ~clr_stat[s]) | ev_vec[s];
      end

      // R7: every raw event is recorded for polling
      assert_stat_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ev_vec[s] |=> stat_q[s]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         cfg_rise_q <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == A_ENA) en_q       <= bus_wdata[FLAG_N-1:0];
         if (bus_addr == A_CFG) cfg_rise_q <= bus_wdata[0];
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (bus_addr)
         A_FLAG:  rd_mux[FLAG_N-1:0] = flag_q;
         A_ENA:   rd_mux[FLAG_N-1:0] = en_q;
         A_STAT:  rd_mux[FLAG_N-1:0] = {pres_level, stat_q};
         default: rd_mux[0]          = cfg_rise_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
   assign irq       = |(flag_q & en_q);

   // R5: a flag-register read never lets a new flag bit appear behind it
   assert_no_new_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_flag |=> ((flag_q & ~$past(flag_q)) == '0));
   // R10: read data only moves after a read strobe
   assert_rdata_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   // R10: unused read bits stay zero
   assert_rdata_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:FLAG_N] == {PAD_W{1'b0}});
endmodule

// File: tb/sc_irq_ctrl_tb.sv
module sc_irq_ctrl_tb;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_rd = 1'b0, bus_wr = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [5:0]    ev = '0;
   logic          card_pres = 1'b0;
   logic          irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model state
   logic [6:0]    m_flag = '0, m_en = '0, m_hold = '0;
   logic [5:0]    m_stat = '0;
   logic          m_rise = 1'b0, m_lvl = 1'b0;
   logic [DW-1:0] m_rdata = '0;

   always #2 clk = ~clk;   // 250 MHz

   sc_irq_ctrl #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_txbuf(ev[0]), .ev_vcc(ev[1]), .ev_wt(ev[2]), .ev_txdone(ev[3]),
      .ev_rxdone(ev[4]), .ev_parity(ev[5]), .card_pres(card_pres), .irq(irq)
   );

   function automatic logic [DW-1:0] reg_view(input logic [1:0] a);
      logic [DW-1:0] r = '0;
      case (a)
         2'd0:    r[6:0] = m_flag;
         2'd1:    r[6:0] = m_en;
         2'd2:    r[6:0] = {m_lvl, m_stat};
         default: r[0]   = m_rise;
      endcase
      return r;
   endfunction

   task automatic model_step(input logic [5:0] e, input logic rd, input logic wr,
                             input logic [1:0] a, input logic [DW-1:0] wd);
      logic [6:0] ge, setv, clr;
      ge = {1'b0, e} & m_en;
      if (rd) m_rdata = reg_view(a);
      if (rd && a == 2'd0) begin setv = '0; m_hold = m_hold | ge; end
      else begin setv = m_hold | ge; m_hold = '0; end
      clr = (wr && a == 2'd0) ? wd[6:0] : '0;
      m_flag = (m_flag & ~clr) | setv;
      m_stat = (m_stat & ~((wr && a == 2'd2) ? wd[5:0] : 6'd0)) | e;
      if (wr && a == 2'd1) m_en = wd[6:0];
      if (wr && a == 2'd3) m_rise = wd[0];
   endtask

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // one bus cycle: drive at negedge, check at following negedge
   task automatic cyc(input string tag, input logic [5:0] e, input logic rd,
                      input logic wr, input logic [1:0] a, input logic [DW-1:0] wd);
      ev = e; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      model_step(e, rd, wr, a, wd);
      @(negedge clk);
      ev = '0; bus_rd = 1'b0; bus_wr = 1'b0;
      check(tag, "irq", {7'd0, irq}, {7'd0, |(m_flag & m_en)});
      if (rd) check(tag, "rdata", bus_rdata, m_rdata);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5C1A_0007));
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "irq at reset", {7'd0, irq}, '0);
      check("R9", "rdata at reset", bus_rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 4; a++) cyc("R9", '0, 1'b1, 1'b0, a[1:0], '0);

      // R1/R2: enabled event sets flag and irq
      cyc("R1", '0, 1'b0, 1'b1, 2'd1, 8'h3F);
      cyc("R2", 6'h08, 1'b0, 1'b0, 2'd0, '0);
      cyc("R1", '0, 1'b1, 1'b0, 2'd0, '0);
      // R3: writing zeros keeps flags, bits above 6 ignored
      cyc("R3", '0, 1'b0, 1'b1, 2'd0, 8'h80);
      cyc("R3", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R3", '0, 1'b0, 1'b1, 2'd0, 8'h08);
      cyc("R3", '0, 1'b1, 1'b0, 2'd0, '0);
      // R4: clear and event same cycle
      cyc("R4", 6'h01, 1'b0, 1'b0, 2'd0, '0);
      cyc("R4", 6'h01, 1'b0, 1'b1, 2'd0, 8'h01);
      cyc("R4", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R4", '0, 1'b0, 1'b1, 2'd0, 8'h7F);
      // R5: event during read is held, merged across back-to-back reads
      cyc("R5", 6'h10, 1'b1, 1'b0, 2'd0, '0);
      cyc("R5", '0, 1'b0, 1'b0, 2'd0, '0);
      cyc("R5", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R5", '0, 1'b0, 1'b1, 2'd0, 8'h7F);
      cyc("R5", 6'h04, 1'b1, 1'b0, 2'd0, '0);
      cyc("R5", 6'h04, 1'b1, 1'b0, 2'd0, '0);
      cyc("R5", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R5", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R5", '0, 1'b0, 1'b1, 2'd0, 8'h7F);
      // R6/R7: disabled source, status records it
      cyc("R6", '0, 1'b0, 1'b1, 2'd1, 8'h37);
      cyc("R6", 6'h08, 1'b0, 1'b0, 2'd0, '0);
      cyc("R6", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R7", '0, 1'b1, 1'b0, 2'd2, '0);
      cyc("R7", '0, 1'b0, 1'b1, 2'd2, 8'hFF);
      cyc("R7", '0, 1'b1, 1'b0, 2'd2, '0);

      // R8: card presence edges
      cyc("R8", '0, 1'b0, 1'b1, 2'd1, 8'h40);
      cyc("R8", '0, 1'b0, 1'b1, 2'd3, 8'h01);
      card_pres = 1'b1; idle(5); m_lvl = 1'b1; m_flag[6] = 1'b1;
      check("R8", "irq after rising edge", {7'd0, irq}, 8'd1);
      cyc("R8", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R7", '0, 1'b1, 1'b0, 2'd2, '0);
      cyc("R8", '0, 1'b0, 1'b1, 2'd0, 8'h40);
      card_pres = 1'b0; idle(5); m_lvl = 1'b0;
      check("R8", "falling ignored when rising set", {7'd0, irq}, '0);
      cyc("R8", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R8", '0, 1'b0, 1'b1, 2'd3, 8'h00);
      card_pres = 1'b1; idle(5); m_lvl = 1'b1;
      check("R8", "rising ignored when falling set", {7'd0, irq}, '0);
      card_pres = 1'b0; idle(5); m_lvl = 1'b0; m_flag[6] = 1'b1;
      check("R8", "irq after falling edge", {7'd0, irq}, 8'd1);
      cyc("R8", '0, 1'b1, 1'b0, 2'd0, '0);
      cyc("R8", '0, 1'b0, 1'b1, 2'd0, 8'h7F);

      // random phase, card level held low
      for (int n = 0; n < 4000; n++) begin
         logic [5:0]    e;
         logic [1:0]    a;
         logic [DW-1:0] wd;
         int            op;
         e  = 6'($urandom & $urandom & 32'h3F);
         a  = 2'($urandom);
         wd = DW'($urandom);
         op = int'($urandom % 8);
         if (op < 3)      cyc("R5", e, 1'b1, 1'b0, a, '0);
         else if (op < 5) cyc("R3", e, 1'b0, 1'b1, a, wd);
         else             cyc("R2", e, 1'b0, 1'b0, a, '0);
      end
      cyc("R10", '0, 1'b1, 1'b0, 2'd1, '0);
      cyc("R10", '0, 1'b0, 1'b0, 2'd0, '0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule